// File: doc/BRIEF.md
# Accumulator Shift-Round-Saturate Extractor

This unit takes one of several wide signed accumulators, shifts it arithmetically right by a small amount, and returns a 32-bit word. It is meant to sit beside a DSP accumulator file. One request per handshake carries the accumulator slot, the operation code and two possible shift sources. The answer is registered and leaves through a valid/ready output. The same output beat also carries a one-cycle request to set the sticky overflow bit of the control register.

The word forms keep one guard bit below the result. The accumulator is shifted by one less than asked and the guard bit is dropped at the end. In the rounding forms a one is added into the guard position before the drop. A shift of zero therefore still rounds. Overflow is judged twice, once on the intermediate before the increment and once after it. For this reason the plain and round forms can raise the flag without clamping. The round-saturate form also replaces an out-of-range result with the nearest 32-bit limit. The halfword form clamps the shifted value to signed 16 bits and sign-extends it to the full word.

Back-pressure works as follows. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. A presented result stays unchanged while `out_ready` is low.

Top module: `acc_extract`

## Requirements
- R1: After reset `out_valid` is 0, `ovf_set` is 0 and `in_ready` is 1.
- R2: A request taken on a clock edge appears at the output on the next edge with `out_valid` high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `result` stays stable.
- R3: Bit 0 of `op_code` selects the shift source: 0 takes `shift_imm` and 1 takes `shift_reg`. Only the low 4 bits of the chosen source are used, so shifts range over 0..15. The source that is not chosen has no effect on the result.
- R4: `acc_sel` picks the accumulator, where slot k is `acc_flat[64k+63:64k]`. The other slots have no effect.
- R5: Codes 0x00 and 0x01 (plain) return the low 32 bits of floor(acc / 2^s).
- R6: Codes 0x04 and 0x05 (round) return the low 32 bits of floor((acc*2/2^s + 1) / 2), where the division is floored. This applies for every s, including s = 0.
- R7: For the word forms, let t = floor(acc*2/2^s). The request is flagged when t, or t+1, does not fit in a 33-bit signed value. The flag does not depend on whether the result is clamped.
- R8: Codes 0x06 and 0x07 (round-saturate) return 0x7FFFFFFF when t+1 does not fit and is non-negative, and 0x80000000 when it does not fit and is negative. Otherwise they return the rounded value. Flagging follows R7.
- R9: Codes 0x0E and 0x0F (halfword) compute floor(acc / 2^s). A value above 32767 becomes 0x00007FFF and a value below -32768 becomes 0xFFFF8000; either clamp flags the request. Any other value is returned sign-extended to 32 bits.
- R10: `ovf_set` is high only in the output handshake cycle (`out_valid && out_ready`) of a flagged result, for exactly one cycle per result.
- R11: Any other `op_code` returns 0 and is never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| acc_flat | input | 256 | Four 64-bit accumulators, slot 0 lowest |
| acc_sel | input | 2 | Accumulator slot index |
| op_code | input | 5 | Operation code (see R3, R5 to R11) |
| shift_imm | input | 5 | Immediate shift source |
| shift_reg | input | 32 | Register-operand shift source |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| result | output | 32 | Extracted word |
| ovf_set | output | 1 | Pulse requesting the sticky overflow bit be set |

## Verification
The bench uses the default parameters: four 64-bit accumulator slots, a 32-bit result, a 16-bit halfword and a 4-bit shift mask. Because the largest shift is 15, an accumulator only slightly above 2^32 already reaches both overflow checks and the saturation limits. The bench places these values next to small values that do round, so the case where the flag rises without a clamp and the case of rounding at a zero shift are both covered. It fills the unused slots and the unused shift source with distinctive values, so that a wrong selection or a missing mask changes the result.

// File: rtl/acx_pkg.sv
package acx_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_ROUND = 2'd1,
    KIND_RSAT  = 2'd2,
    KIND_HALF  = 2'd3
  } kind_e;

  // Upper four code bits name the operation; bit 0 names the shift source.
  localparam logic [3:0] GRP_PLAIN = 4'h0;
  localparam logic [3:0] GRP_ROUND = 4'h2;
  localparam logic [3:0] GRP_RSAT  = 4'h3;
  localparam logic [3:0] GRP_HALF  = 4'h7;

endpackage

// File: rtl/acx_decode.sv
module acx_decode
  import acx_pkg::*;
#(
  parameter int IMM_W   = 5,
  parameter int REG_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic [4:0]         op_code,
  input  logic [IMM_W-1:0]   shift_imm,
  input  logic [REG_W-1:0]   shift_reg,
  output kind_e              kind,
  output logic               legal,
  output logic [SHIFT_W-1:0] shamt
);

  logic [3:0] grp;
  assign grp = op_code[4:1];

  always_comb begin
    legal = 1'b1;
    kind  = KIND_PLAIN;
    unique case (grp)
      GRP_PLAIN: kind = KIND_PLAIN;
      GRP_ROUND: kind = KIND_ROUND;
      GRP_RSAT:  kind = KIND_RSAT;
      GRP_HALF:  kind = KIND_HALF;
      default:   legal = 1'b0;
    endcase
  end

  assign shamt = op_code[0] ? shift_reg[SHIFT_W-1:0] : shift_imm[SHIFT_W-1:0];

endmodule

// File: rtl/acx_acc_select.sv
module acx_acc_select #(
  parameter int NUM_ACC = 4,
  parameter int ACC_W   = 64,
  localparam int SEL_W  = $clog2(NUM_ACC)
) (
  input  logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input  logic [SEL_W-1:0]         acc_sel,
  output logic [ACC_W-1:0]         acc
);

  logic [ACC_W-1:0] slots [NUM_ACC];

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_slot
    assign slots[g] = acc_flat[g*ACC_W +: ACC_W];
  end

  assign acc = slots[acc_sel];

endmodule

// File: rtl/acx_word_path.sv
module acx_word_path
  import acx_pkg::*;
#(
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic [SHIFT_W-1:0] shamt,
  input  kind_e              kind,
  output logic [RES_W-1:0]   res,
  output logic               ovf
);

  // Sign bit, accumulator, guard bit.
  localparam int TW = ACC_W + 2;
  localparam logic [RES_W-1:0] POS_LIM = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG_LIM = {1'b1, {(RES_W-1){1'b0}}};

  logic signed [TW-1:0] base, trunc_v, rnd_v;
  logic                 pre_ok, post_ok;

  function automatic logic fits(input logic [TW-1:0] x);
    logic [TW-1-RES_W:0] top;
    top  = x[TW-1:RES_W];
    fits = (&top) || (~|top);
  endfunction

  assign base    = {acc[ACC_W-1], acc, 1'b0};
  assign trunc_v = base >>> shamt;
  assign rnd_v   = trunc_v + TW'(1);
  assign pre_ok  = fits(trunc_v);
  assign post_ok = fits(rnd_v);

  always_comb begin
    ovf = !(pre_ok && post_ok);
    unique case (kind)
      KIND_ROUND: res = rnd_v[RES_W:1];
      KIND_RSAT:  res = post_ok ? rnd_v[RES_W:1]
                                : (rnd_v[TW-1] ? NEG_LIM : POS_LIM);
      default:    res = trunc_v[RES_W:1];
    endcase
  end

endmodule

// File: rtl/acx_half_path.sv
module acx_half_path #(
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int HALF_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic [ACC_W-1:0]   acc,
  input  logic [SHIFT_W-1:0] shamt,
  output logic [RES_W-1:0]   res,
  output logic               ovf
);

  localparam int EXT_W = RES_W - HALF_W;

  logic signed [ACC_W-1:0]  shifted;
  logic [ACC_W-HALF_W:0]    upper;
  logic                     in_range, neg;

  assign shifted  = $signed(acc) >>> shamt;
  assign upper    = shifted[ACC_W-1:HALF_W-1];
  assign in_range = (&upper) || (~|upper);
  assign neg      = shifted[ACC_W-1];
  assign ovf      = !in_range;

  always_comb begin
    if (in_range)
      res = {{EXT_W{shifted[HALF_W-1]}}, shifted[HALF_W-1:0]};
    else
      res = {{(EXT_W+1){neg}}, {(HALF_W-1){~neg}}};
  end

endmodule

// File: rtl/acc_extract.sv
module acc_extract
  import acx_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int ACC_W   = 64,
  parameter int RES_W   = 32,
  parameter int HALF_W  = 16,
  parameter int IMM_W   = 5,
  parameter int SHIFT_W = 4,
  localparam int SEL_W  = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input  logic [SEL_W-1:0]         acc_sel,
  input  logic [4:0]               op_code,
  input  logic [IMM_W-1:0]         shift_imm,
  input  logic [RES_W-1:0]         shift_reg,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [RES_W-1:0]         result,
  output logic                     ovf_set
);

  kind_e              kind;
  logic               legal;
  logic [SHIFT_W-1:0] shamt;
  logic [ACC_W-1:0]   acc;
  logic [RES_W-1:0]   word_res, half_res, next_res;
  logic               word_ovf, half_ovf, next_ovf;
  logic               flag_q;
  logic               take;

  acx_decode #(.IMM_W(IMM_W), .REG_W(RES_W), .SHIFT_W(SHIFT_W)) u_dec (
    .op_code   (op_code),
    .shift_imm (shift_imm),
    .shift_reg (shift_reg),
    .kind      (kind),
    .legal     (legal),
    .shamt     (shamt)
  );

  acx_acc_select #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W)) u_sel (
    .acc_flat (acc_flat),
    .acc_sel  (acc_sel),
    .acc      (acc)
  );

  acx_word_path #(.ACC_W(ACC_W), .RES_W(RES_W), .SHIFT_W(SHIFT_W)) u_word (
    .acc   (acc),
    .shamt (shamt),
    .kind  (kind),
    .res   (word_res),
    .ovf   (word_ovf)
  );

  acx_half_path #(.ACC_W(ACC_W), .RES_W(RES_W), .HALF_W(HALF_W), .SHIFT_W(SHIFT_W)) u_half (
    .acc   (acc),
    .shamt (shamt),
    .res   (half_res),
    .ovf   (half_ovf)
  );

  always_comb begin
    if (!legal) begin
      next_res = '0;
      next_ovf = 1'b0;
    end else if (kind == KIND_HALF) begin
      next_res = half_res;
      next_ovf = half_ovf;
    end else begin
      next_res = word_res;
      next_ovf = word_ovf;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_q    <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      result    <= next_res;
      flag_q    <= next_ovf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      flag_q    <= 1'b0;
    end
  end

  assign ovf_set = out_valid && out_ready && flag_q;

endmodule

// File: rtl/acx_checker.sv
module acx_checker #(
  parameter int RES_W  = 32,
  parameter int HALF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [4:0]       op_code,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] result,
  input logic             ovf_set
);

  localparam logic [RES_W-1:0] POS_LIM = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG_LIM = {1'b1, {(RES_W-1){1'b0}}};

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result)); // R2

  AST_ACCEPT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2

  AST_OVF_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |-> out_valid && out_ready); // R10

  AST_RSAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && op_code[4:1] == 4'h3) && ovf_set
      |-> (result == POS_LIM || result == NEG_LIM)); // R8

  AST_HALF_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && op_code[4:1] == 4'h7)
      |-> (&result[RES_W-1:HALF_W-1]) || (~|result[RES_W-1:HALF_W-1])); // R9

endmodule

bind acc_extract acx_checker #(.RES_W(RES_W), .HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op_code   (op_code),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .ovf_set   (ovf_set)
);

// File: tb/sim_acc_extract.sv
module sim_acc_extract;

  typedef struct packed {
    logic [1:0]  idx;
    logic [63:0] acc;
    logic [4:0]  op;
    logic [4:0]  simm;
    logic [31:0] sreg;
    logic [31:0] exp;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 64'h100,                 5'h00, 5'd4,  32'hFFFF_FFFF, 32'h0000_0010, 1'b0, 4'd5},  // R5
    '{2'd1, 64'd23,                  5'h04, 5'd1,  32'hFFFF_FFFF, 32'h0000_000C, 1'b0, 4'd6},  // R6
    '{2'd2, 64'd23,                  5'h01, 5'h1F, 32'h0000_0001, 32'h0000_000B, 1'b0, 4'd3},  // R3
    '{2'd3, 64'hFFFF_FFFF_FFFF_FFFB, 5'h04, 5'd1,  32'h0,         32'hFFFF_FFFE, 1'b0, 4'd6},  // R6
    '{2'd0, 64'h1_0000_0000,         5'h00, 5'd0,  32'h0,         32'h0000_0000, 1'b1, 4'd7},  // R7
    '{2'd1, 64'h1_0000_0000,         5'h06, 5'd0,  32'h0,         32'h7FFF_FFFF, 1'b1, 4'd8},  // R8
    '{2'd2, 64'hFFFF_FFFF_0000_0000, 5'h07, 5'h1F, 32'h0000_0010, 32'h8000_0000, 1'b1, 4'd8},  // R8
    '{2'd3, 64'h7FFF_FFFF,           5'h04, 5'd0,  32'h0,         32'h7FFF_FFFF, 1'b0, 4'd6},  // R6
    '{2'd0, 64'hFFFF_FFFF,           5'h05, 5'd0,  32'hFFFF_FFF1, 32'h8000_0000, 1'b1, 4'd7},  // R7
    '{2'd1, 64'hFFFF_FFFF,           5'h00, 5'd1,  32'h0,         32'h7FFF_FFFF, 1'b1, 4'd7},  // R7
    '{2'd2, 64'hFFFF_FFFF,           5'h06, 5'd1,  32'h0,         32'h7FFF_FFFF, 1'b1, 4'd8},  // R8
    '{2'd3, 64'h1234,                5'h0E, 5'd4,  32'h0,         32'h0000_0123, 1'b0, 4'd9},  // R9
    '{2'd0, 64'h10_0000,             5'h0E, 5'd4,  32'h0,         32'h0000_7FFF, 1'b1, 4'd9},  // R9
    '{2'd1, 64'hFFFF_FFFF_FFFE_0000, 5'h0F, 5'd0,  32'h0000_0001, 32'hFFFF_8000, 1'b1, 4'd9},  // R9
    '{2'd2, 64'hFFFF_FFFF_FFFF_8000, 5'h0E, 5'd0,  32'h0,         32'hFFFF_8000, 1'b0, 4'd9},  // R9
    '{2'd3, 64'h7FFF,                5'h0E, 5'd0,  32'h0,         32'h0000_7FFF, 1'b0, 4'd9},  // R9
    '{2'd0, 64'h40,                  5'h01, 5'd0,  32'h0000_0012, 32'h0000_0010, 1'b0, 4'd3},  // R3
    '{2'd1, 64'h8000_0000,           5'h00, 5'd15, 32'h0,         32'h0001_0000, 1'b0, 4'd5},  // R5
    '{2'd2, 64'hFFFF_FFFF_FFFF_FFFB, 5'h00, 5'd1,  32'h0,         32'hFFFF_FFFD, 1'b0, 4'd5},  // R5
    '{2'd3, 64'h5555,                5'h02, 5'd0,  32'h0,         32'h0000_0000, 1'b0, 4'd11}, // R11
    '{2'd0, 64'h8000,                5'h0E, 5'h11, 32'h0,         32'h0000_4000, 1'b0, 4'd3}   // R3
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] acc_flat = '0;
  logic [1:0]   acc_sel = '0;
  logic [4:0]   op_code = '0;
  logic [4:0]   shift_imm = '0;
  logic [31:0]  shift_reg = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  result;
  logic         ovf_set;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  acc_extract u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .acc_flat  (acc_flat),
    .acc_sel   (acc_sel),
    .op_code   (op_code),
    .shift_imm (shift_imm),
    .shift_reg (shift_reg),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result),
    .ovf_set   (ovf_set)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    for (int k = 0; k < 4; k++)
      acc_flat[k*64 +: 64] = (k == int'(v.idx)) ? v.acc : 64'hC3A5_0F1E_7B2D_4000 + 64'(k);
    acc_sel   = v.idx;
    op_code   = v.op;
    shift_imm = v.simm;
    shift_reg = v.sreg;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    vec_t a, b;
    repeat (3) @(negedge clk);
    // R1: idle state under reset
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready",  32'(in_ready),  32'd1);
    check("R1 ovf_set",   32'(ovf_set),   32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].exp);
      check($sformatf("R%0d vec%0d ovf_set", VECS[i].req, i), 32'(ovf_set), 32'(VECS[i].ovf));
      check($sformatf("R2 vec%0d out_valid", i), 32'(out_valid), 32'd1);
    end
    @(negedge clk);
    check("R10 no pulse when idle", 32'(ovf_set), 32'd0);

    // R2 / R10: back-pressure, hold and single pulse
    a = VECS[0];
    b = VECS[4];
    out_ready = 1'b0;
    load(a);
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 result presented", result, 32'h10);
    check("R2 in_ready low while stalled", 32'(in_ready), 32'd0);
    check("R10 no pulse while stalled", 32'(ovf_set), 32'd0);
    load(b);
    @(negedge clk);
    check("R2 result held under stall", result, 32'h10);
    out_ready = 1'b1;
    #1;
    check("R2 in_ready with drain", 32'(in_ready), 32'd1);
    check("R10 unflagged result no pulse", 32'(ovf_set), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second result after drain", result, 32'h0);
    check("R10 flagged pulse", 32'(ovf_set), 32'd1);
    @(negedge clk);
    check("R10 pulse lasts one cycle", 32'(ovf_set), 32'd0);
    check("R2 output empty", 32'(out_valid), 32'd0);

    // R4: other slot contents do not matter
    load(VECS[17]);
    acc_flat[0 +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 slot select", result, 32'h0001_0000);
    check("R4 no flag from other slot", 32'(ovf_set), 32'd0);

    @(negedge clk);
    finish_run();
  end

endmodule